// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block sequences the master side of a shared I/O bus. When a start request arrives it raises a bus request and waits for the arbiter's grant. After one preparation clock it runs either one or two transfer cycles. Each cycle passes through four phases, T1 to T4, and the final phase repeats as long as the slave reports not-ready. The block then releases the bus and goes back to idle. The outputs are the gating strobes that the address and data paths around the block use.

Several strobes change on the falling edge of the bus clock. The block therefore runs on one fast clock that is twice the bus clock. A phase flag alternates between a rising step and a falling step. The first fast edge after reset is a rising step. All inputs are sampled at fast edges. The reset is synchronous to the fast clock.

Top module: `bmc_seq_top`

Output vector used below, from MSB to LSB: bus_req, addr_en, second_cyc, wrden_gate, rd_gate, wr_gate, pre_cyc, end_xfer.

## Requirements
- R1: While rst is high, every output is 0 after the next fast clock edge, whatever the other inputs do. The next fast edge after rst falls is a rising step.
- R2: In idle with start_n high, toggling grant, ready_n or dbl_sel leaves every output at 0.
- R3: start_n low at a rising step in idle sets bus_req at that edge. bus_req stays high after start_n returns high, and the block waits until grant is high at a rising step.
- R4: grant high at a rising step in the request state sets pre_cyc for exactly one bus clock. The following rising step enters T1 with bus_req and addr_en high and pre_cyc low.
- R5: The rising step that enters T2 sets wrden_gate and rd_gate. wr_gate rises at the following falling step.
- R6: ready_n is sampled at the falling steps of T3 and of every T4. A T4 falling step ends the cycle only if the previous falling-step sample was low. Otherwise T4 repeats, so a cycle with N not-ready samples has N extra T4 clocks.
- R7: At the ending falling step, rd_gate and wr_gate drop and wrden_gate stays high until the next rising step.
- R8: If the double mode is latched, the first cycle is followed by a second cycle. It starts at T1 with second_cyc high and wrden_gate low, then repeats T2 to T4.
- R9: end_xfer is high for exactly the half clock after the falling step that ends the last cycle. At the next rising step all outputs are 0 and the block is idle.
- R10: Holding grant high after returning to idle does not start a new request.
- R11: dbl_sel is latched at the rising step that enters the first T1. Later changes to it do not affect the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start request, active low |
| dbl_sel | input | 1 | Selects two transfer cycles |
| grant | input | 1 | Bus grant from the arbiter |
| ready_n | input | 1 | Slave ready, active low |
| bus_req | output | 1 | Bus request |
| addr_en | output | 1 | Address drive enable |
| second_cyc | output | 1 | Second cycle of a double transfer in progress |
| wrden_gate | output | 1 | Write-data drive enable |
| rd_gate | output | 1 | Read strobe gate |
| wr_gate | output | 1 | Write strobe gate |
| pre_cyc | output | 1 | Preparation clock after grant |
| end_xfer | output | 1 | End-of-transfer half-clock pulse |

## Verification
The bench compares every output at every half clock against a hand-derived trace in three scenarios:
- a double transfer with no wait state and then one wait state;
- a single transfer with two wait states;
- a reset that cuts a transfer short.

A design that sampled ready at the wrong half clock would end early or late. The wait-state counts expose this by a whole bus clock. A design that failed to hold wrden_gate past the ending fall, or failed to drop it at the second T1, would show a one-bit difference at those exact steps. The single-cycle run changes dbl_sel to 1 after the latch point. A design that did not latch it would start a spurious second cycle. The idle checks keep grant held high after the transfer, which catches a sequencer that re-arms on grant.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int STATE_W = 3;
    localparam int OUT_W   = 8;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_PREP  = 3'd2,
        ST_T1    = 3'd3,
        ST_T2    = 3'd4,
        ST_T3    = 3'd5,
        ST_T4    = 3'd6
    } bmc_state_e;

    typedef struct packed {
        bmc_state_e st;
        logic       dbl;
        logic       rdy;
        logic       done;
        logic       breq;
        logic       aen;
        logic       cy2;
        logic       wrden;
        logic       rd;
        logic       wr;
        logic       pre;
        logic       eot;
    } bmc_regs_t;

endpackage

// File: rtl/bmc_phase.sv
module bmc_phase (
    input  logic clk,
    input  logic rst,
    output logic rise_step
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ph_d;
    end

    assign rise_step = ~ph_q;
endmodule

// File: rtl/bmc_seq.sv
module bmc_seq
    import bmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_step,
    input  logic      start_n,
    input  logic      dbl_sel,
    input  logic      grant,
    input  logic      ready_n,
    output bmc_regs_t regs
);
    bmc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rise_step) begin
            r_d.eot = 1'b0;
            unique case (r_q.st)
                ST_IDLE: if (!start_n) begin
                    r_d.st   = ST_REQ;
                    r_d.breq = 1'b1;
                end
                ST_REQ: if (grant) begin
                    r_d.st  = ST_PREP;
                    r_d.pre = 1'b1;
                end
                ST_PREP: begin
                    r_d.st   = ST_T1;
                    r_d.aen  = 1'b1;
                    r_d.pre  = 1'b0;
                    r_d.dbl  = dbl_sel;
                    r_d.cy2  = 1'b0;
                    r_d.done = 1'b0;
                end
                ST_T1: begin
                    r_d.st    = ST_T2;
                    r_d.wrden = 1'b1;
                    r_d.rd    = 1'b1;
                end
                ST_T2: r_d.st = ST_T3;
                ST_T3: r_d.st = ST_T4;
                ST_T4: if (r_q.done) begin
                    if (r_q.dbl && !r_q.cy2) begin
                        r_d.st    = ST_T1;
                        r_d.cy2   = 1'b1;
                        r_d.wrden = 1'b0;
                        r_d.done  = 1'b0;
                    end else begin
                        r_d = '0;
                    end
                end
                default: r_d = '0;
            endcase
        end else begin
            unique case (r_q.st)
                ST_T2: r_d.wr = 1'b1;
                ST_T3: r_d.rdy = !ready_n;
                ST_T4: if (!r_q.done) begin
                    if (r_q.rdy) begin
                        r_d.rd   = 1'b0;
                        r_d.wr   = 1'b0;
                        r_d.done = 1'b1;
                        r_d.rdy  = 1'b0;
                        r_d.eot  = !r_q.dbl || r_q.cy2;
                    end else begin
                        r_d.rdy = !ready_n;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign regs = r_q;
endmodule

// File: rtl/bmc_seq_top.sv
module bmc_seq_top
    import bmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_n,
    input  logic dbl_sel,
    input  logic grant,
    input  logic ready_n,
    output logic bus_req,
    output logic addr_en,
    output logic second_cyc,
    output logic wrden_gate,
    output logic rd_gate,
    output logic wr_gate,
    output logic pre_cyc,
    output logic end_xfer
);
    logic      rise_step;
    bmc_regs_t regs;

    bmc_phase phase_i (
        .clk       (clk),
        .rst       (rst),
        .rise_step (rise_step)
    );

    bmc_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .rise_step (rise_step),
        .start_n   (start_n),
        .dbl_sel   (dbl_sel),
        .grant     (grant),
        .ready_n   (ready_n),
        .regs      (regs)
    );

    assign bus_req    = regs.breq;
    assign addr_en    = regs.aen;
    assign second_cyc = regs.cy2;
    assign wrden_gate = regs.wrden;
    assign rd_gate    = regs.rd;
    assign wr_gate    = regs.wr;
    assign pre_cyc    = regs.pre;
    assign end_xfer   = regs.eot;
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk (
    input logic clk,
    input logic rst,
    input logic start_n,
    input logic bus_req,
    input logic addr_en,
    input logic second_cyc,
    input logic wrden_gate,
    input logic rd_gate,
    input logic wr_gate,
    input logic pre_cyc,
    input logic end_xfer
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !(bus_req | addr_en | second_cyc | wrden_gate | rd_gate | wr_gate | pre_cyc | end_xfer));

    assert_req_from_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !$past(start_n));

    assert_prep_no_addr_R4: assert property (@(posedge clk) disable iff (rst)
        pre_cyc |-> (bus_req && !addr_en));

    assert_wr_inside_rd_R5: assert property (@(posedge clk) disable iff (rst)
        wr_gate |-> (rd_gate && addr_en));

    assert_rd_inside_wrden_R7: assert property (@(posedge clk) disable iff (rst)
        rd_gate |-> wrden_gate);

    assert_second_owns_bus_R8: assert property (@(posedge clk) disable iff (rst)
        second_cyc |-> (bus_req && addr_en));

    assert_eot_shape_R9: assert property (@(posedge clk) disable iff (rst)
        end_xfer |-> (wrden_gate && !rd_gate && !wr_gate));

    assert_eot_half_R9: assert property (@(posedge clk) disable iff (rst)
        end_xfer |=> (!end_xfer && !bus_req));
endmodule

bind bmc_seq_top bmc_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_n    (start_n),
    .bus_req    (bus_req),
    .addr_en    (addr_en),
    .second_cyc (second_cyc),
    .wrden_gate (wrden_gate),
    .rd_gate    (rd_gate),
    .wr_gate    (wr_gate),
    .pre_cyc    (pre_cyc),
    .end_xfer   (end_xfer)
);

// File: tb/bmc_seq_top_tb_top.sv
module bmc_seq_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1, dbl_sel = 1'b0, grant = 1'b0, ready_n = 1'b1;
    logic bus_req, addr_en, second_cyc, wrden_gate, rd_gate, wr_gate, pre_cyc, end_xfer;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bmc_seq_top dut_i (
        .clk(clk), .rst(rst), .start_n(start_n), .dbl_sel(dbl_sel),
        .grant(grant), .ready_n(ready_n), .bus_req(bus_req), .addr_en(addr_en),
        .second_cyc(second_cyc), .wrden_gate(wrden_gate), .rd_gate(rd_gate),
        .wr_gate(wr_gate), .pre_cyc(pre_cyc), .end_xfer(end_xfer)
    );

    wire [7:0] obs = {bus_req, addr_en, second_cyc, wrden_gate, rd_gate, wr_gate, pre_cyc, end_xfer};

    task automatic drive(input logic s_n, input logic d, input logic g, input logic r_n);
        start_n = s_n; dbl_sel = d; grant = g; ready_n = r_n;
    endtask

    task automatic step(input logic [7:0] exp, input string tag);
        @(posedge clk);
        #1;
        n_chk++;
        if (obs !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs actual %b expected %b at %0t", tag, obs, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(0, 1, 1, 0); step(8'h00, "R1 reset with inputs active");
        drive(1, 0, 1, 1); step(8'h00, "R1 reset held");
        drive(1, 1, 0, 0); step(8'h00, "R1 reset held");
        rst = 1'b0;
    endtask

    task automatic t_idle_wiggle;
        drive(1, 0, 1, 1); step(8'h00, "R2 grant toggled");
        drive(1, 0, 0, 1); step(8'h00, "R2");
        drive(1, 0, 0, 0); step(8'h00, "R2 ready_n toggled");
        drive(1, 0, 0, 1); step(8'h00, "R2");
        drive(1, 1, 0, 1); step(8'h00, "R2 dbl_sel toggled");
        drive(1, 0, 0, 1); step(8'h00, "R2");
    endtask

    task automatic t_double;
        drive(0, 1, 0, 1); step(8'h80, "R3 request on start");
        drive(1, 1, 0, 1); step(8'h80, "R3 request held");
        step(8'h80, "R3 waiting for grant");
        step(8'h80, "R3 waiting for grant");
        drive(1, 1, 1, 1); step(8'h82, "R4 preparation");
        step(8'h82, "R4 preparation held");
        step(8'hC0, "R4 first T1");
        step(8'hC0, "R4 T1 fall");
        step(8'hD8, "R5 T2 rise");
        step(8'hDC, "R5 write gate half clock later");
        drive(1, 1, 1, 0); step(8'hDC, "R6 T3");
        step(8'hDC, "R6 T3 sample");
        step(8'hDC, "R6 T4");
        step(8'hD0, "R7 end fall keeps wrden");
        step(8'hE0, "R8 second T1 drops wrden");
        drive(1, 1, 1, 1); step(8'hE0, "R8");
        step(8'hF8, "R8 second T2");
        step(8'hFC, "R5 second write gate");
        step(8'hFC, "R6 second T3");
        step(8'hFC, "R6 not ready sampled");
        drive(1, 1, 1, 0); step(8'hFC, "R6 T4");
        step(8'hFC, "R6 wait state, no end");
        step(8'hFC, "R6 repeated T4");
        step(8'hF1, "R9 end pulse on last fall");
        step(8'h00, "R9 idle after end");
        step(8'h00, "R10 grant held in idle");
        step(8'h00, "R10 grant held in idle");
        drive(1, 0, 0, 1); step(8'h00, "R10");
    endtask

    task automatic t_single;
        drive(0, 0, 0, 1); step(8'h80, "R3 request");
        drive(1, 0, 0, 1); step(8'h80, "R3");
        step(8'h80, "R3");
        step(8'h80, "R3");
        drive(1, 0, 1, 1); step(8'h82, "R4");
        step(8'h82, "R4");
        step(8'hC0, "R11 T1 latches single");
        drive(1, 1, 1, 1); step(8'hC0, "R11 dbl_sel raised late");
        step(8'hD8, "R5");
        step(8'hDC, "R5");
        step(8'hDC, "R6 T3");
        step(8'hDC, "R6 T3 not ready");
        step(8'hDC, "R6 T4");
        step(8'hDC, "R6 first wait");
        drive(1, 1, 1, 0); step(8'hDC, "R6 T4 again");
        step(8'hDC, "R6 second wait");
        step(8'hDC, "R6 T4 third");
        step(8'hD1, "R9 single end pulse");
        step(8'h00, "R11 no second cycle");
        drive(1, 0, 0, 1); step(8'h00, "R9 idle");
    endtask

    task automatic t_abort;
        drive(0, 0, 1, 0); step(8'h80, "R3");
        drive(1, 0, 1, 0); step(8'h80, "R3");
        step(8'h82, "R4");
        step(8'h82, "R4");
        step(8'hC0, "R4");
        rst = 1'b1; step(8'h00, "R1 reset mid transfer");
        rst = 1'b0; drive(1, 0, 1, 1);
        step(8'h00, "R10 idle after reset");
        step(8'h00, "R10");
    endtask

    initial begin
        t_reset();
        t_idle_wiggle();
        t_double();
        t_single();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule